// File: doc/BRIEF.md
# Dual Pseudo-Channel Request Admission

This block sits at the front of a memory controller that serves two pseudo channels sharing one command path. Each incoming request carries an address, a direction (read or write) and the number of queue entries it needs. One address bit steers the request to a pseudo channel, so consecutive 64-byte blocks alternate between the two. The request is then admitted or refused against that channel's own share of the queue capacity. The total read capacity and the total write capacity are each split evenly between the channels. Read admission also counts the entries that the channel's response path still holds.

The block keeps one occupancy counter for each channel and direction. An admitted request adds its entry count to its counter. A completion strobe from the scheduler removes one entry. A refused request leaves a sticky retry mark for its own channel and direction. When that counter again has room for one entry, the block emits a single retry pulse and clears the mark. A request whose address lies outside the served memory is consumed without being enqueued and is flagged as an error. A channel whose two counters are both zero is idle; admitting a request into it raises a wake-up strobe for that channel's scheduler.

Top module: `pcadm_admit`

## Requirements
- R1: After reset, all four occupancy counters read zero, no retry pulse is output, and an in-range request needing one entry is admitted.
- R2: Address bit 6 selects the channel: a value of 0 means channel 0 and a value of 1 means channel 1. An admitted request is presented on the enqueue outputs with `enq_ch` equal to that bit, the same direction and the same entry count.
- R3: A request whose address is at or above `MEM_BYTES` (0xC000 by default) raises `req_err` and is consumed (`req_ready` = 1). It is not enqueued, changes no counter and sets no retry mark.
- R4: A write is admitted only when the channel's write occupancy plus its entry count is at most WR_CAP/2. Otherwise `req_ready` is 0.
- R5: A read is admitted only when the channel's read occupancy plus that channel's `resp_occ` plus its entry count is at most RD_CAP/2. Otherwise `req_ready` is 0.
- R6: On the clock edge that admits a request, the addressed counter rises by the entry count. A dequeue strobe lowers its counter by one. When both happen on the same edge, the net change is count minus one, so a one-entry enqueue together with a dequeue leaves the counter unchanged.
- R7: A dequeue strobe on a counter that is zero, with no enqueue to that counter on the same edge, is ignored and the counter stays zero.
- R8: An in-range request that is still refused at a clock edge sets the retry mark of its own channel and direction only. The other three retry outputs are unaffected.
- R9: A set retry mark produces exactly one one-cycle pulse on its retry output once its counter has room for one entry. For reads, room counts `resp_occ`. The mark is cleared with the pulse, and no further pulse follows without a new refusal.
- R10: `kick[c]` is high in the cycle a request is admitted into channel c while both of that channel's counters are zero.
- R11: Traffic and occupancy on one channel do not change the other channel's counters or its admission decision.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request consumed this cycle (admitted or dropped as out of range) |
| req_addr | input | AW | Request byte address |
| req_write | input | 1 | 1 = write, 0 = read |
| req_beats | input | BW | Queue entries the request needs (1 or more) |
| resp_occ | input | 2*CW | Response-path entries held, one CW field per channel |
| deq_rd | input | 2 | Per channel: one read entry completed |
| deq_wr | input | 2 | Per channel: one write entry completed |
| enq_valid | output | 1 | Admitted request enqueued this cycle |
| enq_ch | output | 1 | Channel of the enqueued request |
| enq_write | output | 1 | Direction of the enqueued request |
| enq_beats | output | BW | Entry count of the enqueued request |
| kick | output | 2 | Per channel: wake-up strobe for the scheduler |
| req_err | output | 1 | Request address outside the served memory |
| rd_occ | output | 2*CW | Read occupancy, one CW field per channel |
| wr_occ | output | 2*CW | Write occupancy, one CW field per channel |
| retry_rd | output | 2 | Per channel: read retry pulse |
| retry_wr | output | 2 | Per channel: write retry pulse |

## Verification
A counter that drifts shows at the occupancy outputs on the edge after the faulty update. It then shifts the admit/refuse boundary, which the sweep sees at the next probe of `req_ready`. A retry mark that is lost or stuck shows within a few cycles as a missing pulse or a repeated one after the room returns. A mark set on the wrong channel or direction shows as a pulse on another retry line. Steering faults show in the same cycle, on `enq_ch` and in which channel's counter moves.

// File: rtl/pcadm_pkg.sv
package pcadm_pkg;

  // Room check: held entries plus requested entries must not pass the limit.
  function automatic logic has_room(input int unsigned held,
                                    input int unsigned extra,
                                    input int unsigned need,
                                    input int unsigned limit);
    return (held + extra + need) <= limit;
  endfunction

  // Next counter value. A decrement on an empty counter with no add is dropped.
  function automatic int unsigned occ_next(input int unsigned cur,
                                           input logic add_en,
                                           input int unsigned add_n,
                                           input logic sub_en);
    int unsigned sum;
    sum = cur + (add_en ? add_n : 0);
    if (sub_en && sum != 0) sum = sum - 1;
    return sum;
  endfunction

endpackage

// File: rtl/pcadm_steer.sv
module pcadm_steer #(
  parameter int AW        = 16,
  parameter int SEL_BIT   = 6,
  parameter int unsigned MEM_BYTES = 32'h0000_C000
) (
  input  logic [AW-1:0] addr,
  output logic          lane,
  output logic          in_range
);
  assign lane     = addr[SEL_BIT];
  assign in_range = 32'(addr) < MEM_BYTES;
endmodule

// File: rtl/pcadm_occ.sv
module pcadm_occ #(
  parameter int CW = 4,
  parameter int BW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          add_en,
  input  logic [BW-1:0] add_n,
  input  logic          sub_en,
  output logic [CW-1:0] occ
);
  import pcadm_pkg::*;

  logic [CW-1:0] occ_q;
  logic [CW-1:0] occ_d;

  always_comb occ_d = CW'(occ_next(32'(occ_q), add_en, 32'(add_n), sub_en));

  always_ff @(posedge clk) begin
    if (!rst_n) occ_q <= '0;
    else        occ_q <= occ_d;
  end

  assign occ = occ_q;
endmodule

// File: rtl/pcadm_retry.sv
module pcadm_retry (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic room_i,
  output logic flag_o,
  output logic pulse_o
);
  logic flag_q;
  logic pulse_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flag_q  <= 1'b0;
      pulse_q <= 1'b0;
    end else begin
      flag_q  <= set_i | (flag_q & ~room_i);
      pulse_q <= flag_q & room_i & ~set_i;
    end
  end

  assign flag_o  = flag_q;
  assign pulse_o = pulse_q;
endmodule

// File: rtl/pcadm_admit.sv
module pcadm_admit #(
  parameter int AW        = 16,
  parameter int SEL_BIT   = 6,
  parameter int unsigned MEM_BYTES = 32'h0000_C000,
  parameter int RD_CAP    = 16,
  parameter int WR_CAP    = 16,
  parameter int BW        = 3,
  localparam int HALF_RD  = RD_CAP / 2,
  localparam int HALF_WR  = WR_CAP / 2,
  localparam int HALF_MAX = (HALF_RD > HALF_WR) ? HALF_RD : HALF_WR,
  localparam int CW       = $clog2(HALF_MAX + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_valid,
  output logic                 req_ready,
  input  logic [AW-1:0]        req_addr,
  input  logic                 req_write,
  input  logic [BW-1:0]        req_beats,
  input  logic [1:0][CW-1:0]   resp_occ,
  input  logic [1:0]           deq_rd,
  input  logic [1:0]           deq_wr,
  output logic                 enq_valid,
  output logic                 enq_ch,
  output logic                 enq_write,
  output logic [BW-1:0]        enq_beats,
  output logic [1:0]           kick,
  output logic                 req_err,
  output logic [1:0][CW-1:0]   rd_occ,
  output logic [1:0][CW-1:0]   wr_occ,
  output logic [1:0]           retry_rd,
  output logic [1:0]           retry_wr
);
  import pcadm_pkg::*;

  // Named internal events
  logic       lane;
  logic       in_range;
  logic [1:0] rd_fit;
  logic [1:0] wr_fit;
  logic [1:0] rd_room;
  logic [1:0] wr_room;
  logic       fit_sel;
  logic       accept;
  logic       reject;
  logic [1:0] acc_rd;
  logic [1:0] acc_wr;
  logic [1:0] rej_rd;
  logic [1:0] rej_wr;
  logic [1:0] flag_rd;
  logic [1:0] flag_wr;

  pcadm_steer #(
    .AW(AW), .SEL_BIT(SEL_BIT), .MEM_BYTES(MEM_BYTES)
  ) u_steer (
    .addr(req_addr), .lane(lane), .in_range(in_range)
  );

  assign fit_sel   = req_write ? wr_fit[lane] : rd_fit[lane];
  assign req_ready = ~in_range | fit_sel;
  assign accept    = req_valid & in_range & fit_sel;
  assign reject    = req_valid & in_range & ~fit_sel;
  assign req_err   = req_valid & ~in_range;

  assign enq_valid = accept;
  assign enq_ch    = lane;
  assign enq_write = req_write;
  assign enq_beats = req_beats;

  for (genvar c = 0; c < 2; c++) begin : g_lane
    logic hit;
    assign hit = (lane == 1'(c));

    assign rd_fit[c]  = has_room(32'(rd_occ[c]), 32'(resp_occ[c]),
                                 32'(req_beats), HALF_RD);
    assign wr_fit[c]  = has_room(32'(wr_occ[c]), 0, 32'(req_beats), HALF_WR);
    assign rd_room[c] = has_room(32'(rd_occ[c]), 32'(resp_occ[c]), 1, HALF_RD);
    assign wr_room[c] = has_room(32'(wr_occ[c]), 0, 1, HALF_WR);

    assign acc_rd[c] = accept & hit & ~req_write;
    assign acc_wr[c] = accept & hit &  req_write;
    assign rej_rd[c] = reject & hit & ~req_write;
    assign rej_wr[c] = reject & hit &  req_write;

    assign kick[c] = accept & hit & (rd_occ[c] == '0) & (wr_occ[c] == '0);

    pcadm_occ #(.CW(CW), .BW(BW)) u_rd_occ (
      .clk(clk), .rst_n(rst_n), .add_en(acc_rd[c]), .add_n(req_beats),
      .sub_en(deq_rd[c]), .occ(rd_occ[c])
    );
    pcadm_occ #(.CW(CW), .BW(BW)) u_wr_occ (
      .clk(clk), .rst_n(rst_n), .add_en(acc_wr[c]), .add_n(req_beats),
      .sub_en(deq_wr[c]), .occ(wr_occ[c])
    );

    pcadm_retry u_rd_retry (
      .clk(clk), .rst_n(rst_n), .set_i(rej_rd[c]), .room_i(rd_room[c]),
      .flag_o(flag_rd[c]), .pulse_o(retry_rd[c])
    );
    pcadm_retry u_wr_retry (
      .clk(clk), .rst_n(rst_n), .set_i(rej_wr[c]), .room_i(wr_room[c]),
      .flag_o(flag_wr[c]), .pulse_o(retry_wr[c])
    );
  end
endmodule

// File: rtl/pcadm_admit_chk.sv
module pcadm_admit_chk #(
  parameter int AW      = 16,
  parameter int SEL_BIT = 6,
  parameter int HALF_RD = 8,
  parameter int HALF_WR = 8,
  parameter int CW      = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic [AW-1:0]      req_addr,
  input logic               req_write,
  input logic               lane,
  input logic               accept,
  input logic               reject,
  input logic               enq_valid,
  input logic               enq_ch,
  input logic               req_err,
  input logic [1:0]         kick,
  input logic [1:0]         deq_rd,
  input logic [1:0]         deq_wr,
  input logic [1:0][CW-1:0] rd_occ,
  input logic [1:0][CW-1:0] wr_occ,
  input logic [1:0]         retry_rd,
  input logic [1:0]         retry_wr,
  input logic [1:0]         flag_rd,
  input logic [1:0]         flag_wr
);
  a_r2_lane_bit: assert property (@(posedge clk) disable iff (!rst_n)
    enq_valid |-> enq_ch == req_addr[SEL_BIT]);

  a_r3_err_no_enq: assert property (@(posedge clk) disable iff (!rst_n)
    req_err |-> (!enq_valid && !reject));

  for (genvar c = 0; c < 2; c++) begin : g_chk
    a_r4_wr_bound: assert property (@(posedge clk) disable iff (!rst_n)
      32'(wr_occ[c]) <= HALF_WR);

    a_r5_rd_bound: assert property (@(posedge clk) disable iff (!rst_n)
      32'(rd_occ[c]) <= HALF_RD);

    a_r7_empty_deq: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_occ[c] == '0 && deq_rd[c] && !(accept && lane == 1'(c) && !req_write))
      |=> rd_occ[c] == '0);

    a_r8_mark_wr: assert property (@(posedge clk) disable iff (!rst_n)
      (reject && req_write && lane == 1'(c)) |=> flag_wr[c]);

    a_r8_mark_rd: assert property (@(posedge clk) disable iff (!rst_n)
      (reject && !req_write && lane == 1'(c)) |=> flag_rd[c]);

    a_r9_single_wr: assert property (@(posedge clk) disable iff (!rst_n)
      retry_wr[c] |=> !retry_wr[c]);

    a_r9_single_rd: assert property (@(posedge clk) disable iff (!rst_n)
      retry_rd[c] |=> !retry_rd[c]);

    a_r10_kick_fills: assert property (@(posedge clk) disable iff (!rst_n)
      (kick[c] && !deq_rd[c] && !deq_wr[c]) |=> (rd_occ[c] != '0 || wr_occ[c] != '0));

    a_r11_wr_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!(accept && lane == 1'(c) && req_write) && !deq_wr[c]) |=> $stable(wr_occ[c]));
  end
endmodule

bind pcadm_admit pcadm_admit_chk #(
  .AW(AW), .SEL_BIT(SEL_BIT), .HALF_RD(HALF_RD), .HALF_WR(HALF_WR), .CW(CW)
) u_chk (
  .clk(clk), .rst_n(rst_n), .req_addr(req_addr), .req_write(req_write),
  .lane(lane), .accept(accept), .reject(reject), .enq_valid(enq_valid),
  .enq_ch(enq_ch), .req_err(req_err), .kick(kick), .deq_rd(deq_rd),
  .deq_wr(deq_wr), .rd_occ(rd_occ), .wr_occ(wr_occ), .retry_rd(retry_rd),
  .retry_wr(retry_wr), .flag_rd(flag_rd), .flag_wr(flag_wr)
);

// File: tb/pcadm_admit_test.sv
module pcadm_admit_test;
  localparam int HALF = 8;
  localparam int CW   = 4;
  localparam int BW   = 3;

  logic                clk = 1'b0;
  logic                rst_n = 1'b0;
  logic                req_valid = 1'b0;
  logic                req_ready;
  logic [15:0]         req_addr = '0;
  logic                req_write = 1'b0;
  logic [BW-1:0]       req_beats = 3'd1;
  logic [1:0][CW-1:0]  resp_occ = '0;
  logic [1:0]          deq_rd = '0;
  logic [1:0]          deq_wr = '0;
  logic                enq_valid;
  logic                enq_ch;
  logic                enq_write;
  logic [BW-1:0]       enq_beats;
  logic [1:0]          kick;
  logic                req_err;
  logic [1:0][CW-1:0]  rd_occ;
  logic [1:0][CW-1:0]  wr_occ;
  logic [1:0]          retry_rd;
  logic [1:0]          retry_wr;

  pcadm_admit uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_write(req_write), .req_beats(req_beats),
    .resp_occ(resp_occ), .deq_rd(deq_rd), .deq_wr(deq_wr),
    .enq_valid(enq_valid), .enq_ch(enq_ch), .enq_write(enq_write),
    .enq_beats(enq_beats), .kick(kick), .req_err(req_err),
    .rd_occ(rd_occ), .wr_occ(wr_occ), .retry_rd(retry_rd), .retry_wr(retry_wr)
  );

  always #4 clk = ~clk;

  int n_cmp = 0;
  int n_bad = 0;
  int m_rd [2];
  int m_wr [2];
  bit finished = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic check_occ(input string tag);
    for (int c = 0; c < 2; c++) begin
      chk(int'(rd_occ[c]) == m_rd[c], {tag, " rd_occ"}, int'(rd_occ[c]), m_rd[c]);
      chk(int'(wr_occ[c]) == m_wr[c], {tag, " wr_occ"}, int'(wr_occ[c]), m_wr[c]);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; req_valid = 1'b0; deq_rd = '0; deq_wr = '0; resp_occ = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    for (int c = 0; c < 2; c++) begin m_rd[c] = 0; m_wr[c] = 0; end
    #1;
    check_occ("R1");
    chk(retry_rd == 2'b00 && retry_wr == 2'b00, "R1 retry idle",
        int'({retry_rd, retry_wr}), 0);
  endtask

  function automatic bit exp_fit(input logic [15:0] a, input bit wr, input int b,
                                 input int resp);
    int l = int'(a[6]);
    if (wr) return (m_wr[l] + b) <= HALF;
    return (m_rd[l] + resp + b) <= HALF;
  endfunction

  // Look at the admission decision without letting a clock edge see the request.
  task automatic probe(input logic [15:0] a, input bit wr, input int b,
                       input int resp, input string tag);
    bit inr, exp_r;
    @(negedge clk);
    req_addr = a; req_write = wr; req_beats = BW'(b);
    resp_occ[a[6]] = CW'(resp);
    req_valid = 1'b1;
    #1;
    inr = a < 16'hC000;
    exp_r = !inr || exp_fit(a, wr, b, resp);
    chk(req_ready == exp_r, tag, int'(req_ready), int'(exp_r));
    req_valid = 1'b0;
  endtask

  // Full handshake with optional dequeues on the addressed channel.
  task automatic send(input logic [15:0] a, input bit wr, input int b,
                      input int resp, input bit dr, input bit dw);
    int l;
    bit inr, fit, acc, k;
    l = int'(a[6]);
    @(negedge clk);
    req_addr = a; req_write = wr; req_beats = BW'(b);
    resp_occ[l] = CW'(resp);
    deq_rd[l] = dr; deq_wr[l] = dw;
    req_valid = 1'b1;
    #1;
    inr = a < 16'hC000;
    fit = exp_fit(a, wr, b, resp);
    acc = inr && fit;
    k = acc && m_rd[l] == 0 && m_wr[l] == 0;
    chk(req_ready == (!inr || fit), wr ? "R4 ready" : "R5 ready",
        int'(req_ready), int'(!inr || fit));
    chk(enq_valid == acc, "R3 enq_valid", int'(enq_valid), int'(acc));
    chk(req_err == !inr, "R3 req_err", int'(req_err), int'(!inr));
    chk(kick == (k ? 2'(1 << l) : 2'b00), "R10 kick", int'(kick),
        k ? (1 << l) : 0);
    if (acc) begin
      chk(int'(enq_ch) == l && enq_write == wr && int'(enq_beats) == b,
          "R2 enqueue fields", int'({enq_ch, enq_write, enq_beats}),
          (l << 4) | (int'(wr) << 3) | b);
    end
    @(posedge clk);
    if (acc && !wr) m_rd[l] += b;
    if (acc && wr)  m_wr[l] += b;
    if (dr && m_rd[l] > 0) m_rd[l] -= 1;
    if (dw && m_wr[l] > 0) m_wr[l] -= 1;
    @(negedge clk);
    req_valid = 1'b0; deq_rd = '0; deq_wr = '0;
    #1;
    check_occ("R6");
  endtask

  task automatic deq(input int c, input bit wr);
    @(negedge clk);
    if (wr) deq_wr[c] = 1'b1; else deq_rd[c] = 1'b1;
    @(negedge clk);
    deq_rd = '0; deq_wr = '0;
    if (wr) begin if (m_wr[c] > 0) m_wr[c] -= 1; end
    else    begin if (m_rd[c] > 0) m_rd[c] -= 1; end
    #1;
    check_occ("R7");
  endtask

  // Counts pulses on one retry line and on the other three lines.
  task automatic watch(input int c, input bit wr, input int cyc,
                       output int own, output int other);
    own = 0; other = 0;
    for (int i = 0; i < cyc; i++) begin
      @(negedge clk); #1;
      for (int k = 0; k < 2; k++) begin
        if (retry_wr[k]) begin if (wr && k == c) own++; else other++; end
        if (retry_rd[k]) begin if (!wr && k == c) own++; else other++; end
      end
    end
  endtask

  initial begin
    #(8 * 150000);
    if (!finished) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    int own, other;
    do_reset();

    // R1: first request accepted, R10 kick into idle channel 1
    send(16'h0040, 1'b1, 1, 0, 0, 0);

    // R4 and R11 sweep: writes, each channel, occupancy 0..HALF, beats 1..4
    for (int c = 0; c < 2; c++) begin
      do_reset();
      for (int occ = 0; occ <= HALF; occ++) begin
        for (int b = 1; b <= 4; b++) begin
          probe(16'(c << 6), 1'b1, b, 0, "R4 write sweep");
          probe(16'((1 - c) << 6), 1'b1, HALF, 0, "R11 other channel free");
        end
        if (occ < HALF) send(16'((c << 6) | 16'h0100), 1'b1, 1, 0, 0, 0);
      end
    end

    // R5 sweep: reads with response occupancy 0..3
    for (int c = 0; c < 2; c++) begin
      for (int r = 0; r <= 3; r++) begin
        do_reset();
        for (int occ = 0; occ <= HALF - r; occ++) begin
          for (int b = 1; b <= 4; b++)
            probe(16'((c << 6) | 16'h0200), 1'b0, b, r, "R5 read sweep");
          if (occ < HALF - r) send(16'(c << 6), 1'b0, 1, r, 0, 0);
        end
      end
    end

    // R3: out of range consumed, no change
    do_reset();
    send(16'h0080, 1'b0, 2, 0, 0, 0);
    send(16'hC040, 1'b1, 1, 0, 0, 0);
    send(16'hFFC0, 1'b0, 1, 0, 0, 0);
    watch(1, 1'b1, 4, own, other);
    chk(own + other == 0, "R3 no retry from error", own + other, 0);

    // R6: enqueue with dequeue on same edge; R7 dequeue on empty
    send(16'h0000, 1'b0, 1, 0, 1, 0);
    send(16'h0000, 1'b0, 3, 0, 1, 0);
    deq(1, 1'b1);
    deq(1, 1'b0);
    send(16'h0040, 1'b1, 1, 0, 0, 1);

    // R8/R9: full write channel 0, refused, then room returns
    do_reset();
    for (int i = 0; i < HALF; i++) send(16'h0000, 1'b1, 1, 0, 0, 0);
    send(16'h0000, 1'b1, 1, 0, 0, 0);
    watch(0, 1'b1, 3, own, other);
    chk(own == 0, "R9 no pulse while full", own, 0);
    chk(other == 0, "R8 other lines quiet", other, 0);
    deq(0, 1'b1);
    watch(0, 1'b1, 5, own, other);
    chk(own == 1, "R9 single write pulse", own, 1);
    chk(other == 0, "R8 other lines quiet after room", other, 0);
    deq(0, 1'b1);
    watch(0, 1'b1, 4, own, other);
    chk(own == 0, "R9 mark cleared", own, 0);

    // R9: multi-entry refusal with room for one pulses once
    send(16'h0000, 1'b1, 4, 0, 0, 0);
    watch(0, 1'b1, 5, own, other);
    chk(own == 1, "R9 pulse after multi-entry refusal", own, 1);

    // R5/R8/R9: read channel 1 held back by response occupancy
    do_reset();
    for (int i = 0; i < 6; i++) send(16'h0040, 1'b0, 1, 2, 0, 0);
    send(16'h0040, 1'b0, 1, 2, 0, 0);
    watch(1, 1'b0, 3, own, other);
    chk(own == 0, "R9 read held by responses", own, 0);
    chk(other == 0, "R8 read mark local", other, 0);
    @(negedge clk);
    resp_occ[1] = CW'(1);
    watch(1, 1'b0, 5, own, other);
    chk(own == 1, "R9 read pulse after response drains", own, 1);
    chk(other == 0, "R8 only read ch1 pulsed", other, 0);

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule